// File: doc/BRIEF.md
# SPI Register-Access Slave with Shared-Pin Read Mode

This block is a serial slave that gives an SPI master read and write access to an external bank of 8-bit registers. The master pulls the select line low, toggles the serial clock and sends a command byte first. That byte carries a direction flag, an auto-increment flag and a 6-bit register index. Data bytes follow, one per 8-clock block, for as long as the select stays low. Each received write byte goes out as a one-cycle write strobe on the register-file port. Read data is taken from the register file's combinational read port and shifted out most significant bit first.

The serial pins are oversampled by the system clock through synchronizers, so all logic runs in one clock domain. The serial clock's high and low phases must each last at least three system clocks. The select line must fall at least three system clocks before the first serial clock edge. A mode input picks where read data appears. In 4-wire operation it appears on the dedicated output pin. In 3-wire operation it appears on the driver of the shared data pin, which stays an input while the command is received.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, and whenever the select input has been high for more than the synchronizer depth, both output enables and the write strobe are low and the data outputs read 0.
- R2: The first 8 serial bits after select falls form the command, sampled on serial clock rising edges. Bit 0 (first sent) is the direction, where 1 means read and 0 means write. Bit 1 is the increment flag, where 1 means auto-increment. Bits 2..7 are the register index, most significant bit first.
- R3: A 16-clock write stores the 8 data bits (bits 8..15, most significant first) into the addressed register with a single write strobe.
- R4: In a read, output drive starts with the falling serial clock edge that begins bit 8. The addressed register's value is shifted out most significant bit first, one bit per falling edge.
- R5: With the increment flag set, each further 8-clock data block uses the next register index, and index 63 is followed by index 0.
- R6: With the increment flag clear, every data block of a burst reads or writes the same register.
- R7: A write strobe is issued only when all 8 bits of a data block have been received. A block cut short by select rising, or a command without data, writes nothing.
- R8: With the 3-wire input high at select fall, read data leaves on the shared-pin driver. Its enable is low during the command bits and high from bit 8 of a read, and the dedicated output enable stays low.
- R9: With the 3-wire input low, read data leaves on the dedicated output and the shared-pin enable never rises. In write transactions neither enable rises in either mode.
- R10: Select rising ends the transaction and releases both output enables within the synchronizer latency plus one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| spc | input | 1 | Serial clock from the master, idles high |
| sdi | input | 1 | Serial data in (the input side of the shared pin in 3-wire mode) |
| three_wire | input | 1 | 1 selects shared-pin read-back, sampled when select falls |
| sdo | output | 1 | Dedicated serial data out |
| sdo_oe | output | 1 | Drive enable for the dedicated output |
| sdio_out | output | 1 | Data for the shared pin driver in 3-wire mode |
| sdio_oe | output | 1 | Drive enable for the shared pin |
| rf_addr | output | 6 | Register index presented to the register file |
| rf_we | output | 1 | One-cycle write strobe |
| rf_wdata | output | 8 | Write data, valid with the strobe |
| rf_rdata | input | 8 | Combinational read data for rf_addr |

## Verification
A wrong bit counter or a phase flag stuck in the command phase shows up at the ports within one transaction. The output enable then rises a bit early or late, or a write strobe is missing or extra, and every data byte compared after it is shifted. A wrong index register, or a wrong increment or wrap, is seen on the next data block of a burst as the wrong register read back or written. A sweep over all 64 indices in both pin modes exposes any stuck index bit. Enable faults linked to the select line are caught by the release check a few clocks after every transaction.

// File: rtl/spi_rf_pkg.sv
// Shared types for the SPI register-access slave.
// Assumes nothing beyond IEEE 1800-2017 packages.
package spi_rf_pkg;

    // Position of the slave inside one select-low frame.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } frame_phase_t;

endpackage

// File: rtl/spi_rf_insync.sv
// Multi-bit synchronizer chain that brings asynchronous pins into the clk domain.
// Assumes each bit is an independent level (no bus coherence is needed).
module spi_rf_insync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= RST_VAL;
                    else        pipe[0] <= d;
                end
            end else begin : g_next
                // Purpose: later settling flops of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_rf_frame.sv
// Frame controller: counts serial bits, decodes the command, keeps the register
// index, issues write strobes and tells the shifter when to load or shift.
// Assumes synchronized inputs and at least three clk cycles between serial edges.
module spi_rf_frame
    import spi_rf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_hi,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi_s,
    input  logic              three_wire,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              tx_load,
    output logic              tx_shift,
    output logic              drive_en,
    output logic              mode3,
    output logic              blk_pulse,
    output logic              ms_bit
);

    localparam int CMD_W = ADDR_W + 2;
    localparam int SH_W  = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int CNT_W = (SH_W > 1) ? $clog2(SH_W) : 1;
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_phase_t      phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SH_W-1:0]   shreg;
    logic [SH_W-1:0]   incoming;
    logic              rw_q;
    logic              ms_q;
    logic [ADDR_W-1:0] addr_q;
    logic              mode3_q;
    logic              oe_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              blk_q;
    logic              last_bit;

    // Purpose: the shift register contents once the current sample is included.
    always_comb begin
        incoming = {shreg[SH_W-2:0], sdi_s};
        last_bit = (phase == PH_CMD) ? (bit_cnt == CMD_LAST) : (bit_cnt == DATA_LAST);
    end

    // Purpose: frame sequencing, command capture, write strobe and index stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            rw_q    <= 1'b0;
            ms_q    <= 1'b0;
            addr_q  <= '0;
            mode3_q <= 1'b0;
            oe_q    <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            blk_q   <= 1'b0;
        end else begin
            we_q  <= 1'b0;
            blk_q <= 1'b0;
            if (blk_q && ms_q) begin
                addr_q <= addr_q + 1'b1;
            end
            if (cs_hi) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else if (phase == PH_IDLE) begin
                phase   <= PH_CMD;
                bit_cnt <= '0;
                mode3_q <= three_wire;
            end else if (rise) begin
                shreg <= incoming;
                if (last_bit) begin
                    bit_cnt <= '0;
                    if (phase == PH_CMD) begin
                        rw_q   <= incoming[CMD_W-1];
                        ms_q   <= incoming[CMD_W-2];
                        addr_q <= incoming[ADDR_W-1:0];
                        phase  <= PH_DATA;
                    end else begin
                        blk_q <= 1'b1;
                        if (!rw_q) begin
                            we_q    <= 1'b1;
                            wdata_q <= incoming[DATA_W-1:0];
                        end
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (fall && phase == PH_DATA && rw_q) begin
                oe_q <= 1'b1;
            end
        end
    end

    // Purpose: shifter controls, active only on falling edges of a read data phase.
    always_comb begin
        tx_load  = fall && !cs_hi && (phase == PH_DATA) && rw_q && (bit_cnt == '0);
        tx_shift = fall && !cs_hi && (phase == PH_DATA) && rw_q && (bit_cnt != '0);
    end

    assign rf_addr   = addr_q;
    assign rf_we     = we_q;
    assign rf_wdata  = wdata_q;
    assign drive_en  = oe_q;
    assign mode3     = mode3_q;
    assign blk_pulse = blk_q;
    assign ms_bit    = ms_q;

endmodule

// File: rtl/spi_rf_txshift.sv
// Read-data shifter: loads a register value at the start of a data block and
// presents one bit per falling serial edge, most significant bit first.
// Assumes rf_rdata is already valid for the current index when tx_load pulses.
module spi_rf_txshift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load,
    input  logic              tx_shift,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              tx_bit
);

    logic [DATA_W-2:0] rest_q;
    logic              bit_q;

    // Purpose: load on block start, otherwise move the next bit forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rest_q <= '0;
            bit_q  <= 1'b0;
        end else if (tx_load) begin
            bit_q  <= rf_rdata[DATA_W-1];
            rest_q <= rf_rdata[DATA_W-2:0];
        end else if (tx_shift) begin
            bit_q  <= rest_q[DATA_W-2];
            rest_q <= {rest_q[DATA_W-3:0], 1'b0};
        end
    end

    assign tx_bit = bit_q;

endmodule

// File: rtl/spi_regbank_slave.sv
// Top of the SPI register-access slave: synchronizes the pins, finds serial
// clock edges, and routes read data to the dedicated or the shared pin driver.
// Assumes serial clock phases of at least three clk cycles each.
module spi_regbank_slave #(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              spc,
    input  logic              sdi,
    input  logic              three_wire,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata
);

    logic [2:0] pins_s;
    logic       cs_s;
    logic       spc_s;
    logic       sdi_s;
    logic       spc_d;
    logic       rise;
    logic       fall;
    logic       tx_load;
    logic       tx_shift;
    logic       tx_bit;
    logic       drive_en;
    logic       mode3;
    logic       blk_pulse;
    logic       ms_bit;

    spi_rf_insync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b011)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sdi, spc, cs_n}),
        .q    (pins_s)
    );

    assign cs_s  = pins_s[0];
    assign spc_s = pins_s[1];
    assign sdi_s = pins_s[2];

    // Purpose: delayed serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) spc_d <= 1'b1;
        else        spc_d <= spc_s;
    end

    assign rise = spc_s & ~spc_d;
    assign fall = ~spc_s & spc_d;

    spi_rf_frame #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_hi     (cs_s),
        .rise      (rise),
        .fall      (fall),
        .sdi_s     (sdi_s),
        .three_wire(three_wire),
        .rf_addr   (rf_addr),
        .rf_we     (rf_we),
        .rf_wdata  (rf_wdata),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift),
        .drive_en  (drive_en),
        .mode3     (mode3),
        .blk_pulse (blk_pulse),
        .ms_bit    (ms_bit)
    );

    spi_rf_txshift #(
        .DATA_W(DATA_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_load (tx_load),
        .tx_shift(tx_shift),
        .rf_rdata(rf_rdata),
        .tx_bit  (tx_bit)
    );

    // Purpose: steer the read bit and its enable to the pin chosen for this frame.
    always_comb begin
        sdo_oe   = drive_en & ~mode3;
        sdio_oe  = drive_en & mode3;
        sdo      = sdo_oe & tx_bit;
        sdio_out = sdio_oe & tx_bit;
    end

endmodule

// File: rtl/spi_regbank_slave_chk.sv
// Checker for the SPI register-access slave, bound to the top module.
// Assumes three_wire is only changed while select is high and idle.
module spi_regbank_slave_chk #(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              three_wire,
    input logic              sdo_oe,
    input logic              sdio_oe,
    input logic              rf_we,
    input logic [ADDR_W-1:0] rf_addr,
    input logic              blk_pulse,
    input logic              ms_bit
);

    localparam int HI_W = $clog2(SYNC_STAGES + 3) + 1;
    localparam logic [HI_W-1:0] HI_SAT = HI_W'(SYNC_STAGES + 2);

    logic [HI_W-1:0] hi_cnt;

    // Purpose: count consecutive cycles with select high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              hi_cnt <= '0;
        else if (!cs_n)          hi_cnt <= '0;
        else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
    end

    // R10 and R1: select held high long enough releases both drivers.
    a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt > HI_W'(SYNC_STAGES)) |-> (!sdo_oe && !sdio_oe));

    // R8 and R9: never both drivers at once.
    a_r8_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe && sdio_oe));

    // R9: the pin used matches the mode input.
    a_r9_pin_by_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe |-> !three_wire) and (sdio_oe |-> three_wire));

    // R7: one strobe per completed block.
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R3: a write never coincides with read drive.
    a_r3_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (!sdo_oe && !sdio_oe));

    // R5: an increment burst steps the index by one after each block.
    a_r5_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_pulse && ms_bit) |=> (rf_addr == $past(rf_addr) + 1'b1));

    // R6: without increment the index holds across a block boundary.
    a_r6_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_pulse && !ms_bit) |=> $stable(rf_addr));

endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .three_wire(three_wire),
    .sdo_oe    (sdo_oe),
    .sdio_oe   (sdio_oe),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .blk_pulse (blk_pulse),
    .ms_bit    (ms_bit)
);

// File: tb/spi_regbank_slave_test.sv
// Bench: models the register file, drives serial frames, computes expected data.
module spi_regbank_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       spc = 1'b1;
    logic       sdi = 1'b0;
    logic       three_wire = 1'b0;
    logic       sdo, sdo_oe, sdio_out, sdio_oe;
    logic [5:0] rf_addr;
    logic       rf_we;
    logic [7:0] rf_wdata;
    logic [7:0] rf_rdata;

    logic [7:0] mem [64];
    int         wr_cnt = 0;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];
    int         oe_bad;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regbank_slave uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .spc(spc), .sdi(sdi),
        .three_wire(three_wire), .sdo(sdo), .sdo_oe(sdo_oe),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .rf_addr(rf_addr),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // Register file model with combinational read and strobe count.
    assign rf_rdata = mem[rf_addr];
    always @(posedge clk) begin
        if (rf_we) begin
            mem[rf_addr] <= rf_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 29 + salt * 71 + 13) & 255);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One frame: command, nbytes data blocks, last 'cut' bits dropped.
    task automatic xfer(input logic rw, input logic ms, input logic [5:0] a,
                        input int nbytes, input int cut, input logic m3);
        logic [7:0] cmd;
        int nbits;
        cmd = {rw, ms, a};
        nbits = 8 + 8 * nbytes - cut;
        oe_bad = 0;
        for (int k = 0; k < 8; k++) rx_buf[k] = 8'h00;
        @(negedge clk);
        three_wire = m3;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            int blk;
            int pos;
            logic exp_drive;
            blk = (b / 8) - 1;
            pos = 7 - (b % 8);
            spc = 1'b0;
            if (b < 8)       sdi = cmd[7 - b];
            else if (!rw)    sdi = tx_buf[blk][pos];
            else             sdi = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            exp_drive = rw && (b >= 8);
            if (sdo_oe !== (exp_drive && !m3))  oe_bad++;
            if (sdio_oe !== (exp_drive && m3))  oe_bad++;
            if (exp_drive) rx_buf[blk][pos] = m3 ? sdio_out : sdo;
            @(negedge clk);
            spc = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        sdi = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 enables released after select rise", int'({sdo_oe, sdio_oe}), 0);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R1 sdo_oe in reset", int'(sdo_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 idle enables", int'({sdo_oe, sdio_oe}), 0);
        chk("R1 idle strobe", int'(rf_we), 0);
        chk("R1 idle data", int'({sdo, sdio_out}), 0);

        // R2 R3: single writes over every index, 4-wire.
        for (int a = 0; a < 64; a++) begin
            int w0;
            w0 = wr_cnt;
            tx_buf[0] = pat(a, 1);
            xfer(1'b0, 1'b0, 6'(a), 1, 0, 1'b0);
            chk("R3 single write value", int'(mem[a]), int'(pat(a, 1)));
            chk("R2 one strobe per write", wr_cnt - w0, 1);
            chk("R9 no drive in write", oe_bad, 0);
        end

        // R4 R9: single reads, 4-wire.
        for (int a = 0; a < 64; a++) begin
            xfer(1'b1, 1'b0, 6'(a), 1, 0, 1'b0);
            chk("R4 read 4-wire data", int'(rx_buf[0]), int'(pat(a, 1)));
            chk("R9 4-wire enable timing", oe_bad, 0);
        end

        // R8: single reads, 3-wire.
        for (int a = 0; a < 64; a++) begin
            xfer(1'b1, 1'b0, 6'(a), 1, 0, 1'b1);
            chk("R8 read 3-wire data", int'(rx_buf[0]), int'(pat(a, 1)));
            chk("R8 3-wire enable timing", oe_bad, 0);
        end

        // R8: a write in 3-wire mode still lands.
        tx_buf[0] = 8'hC6;
        xfer(1'b0, 1'b0, 6'h2A, 1, 0, 1'b1);
        chk("R8 3-wire write value", int'(mem[6'h2A]), 8'hC6);
        chk("R9 3-wire write quiet", oe_bad, 0);

        // R5: increment burst write across the top index.
        for (int k = 0; k < 4; k++) tx_buf[k] = pat(k, 5);
        xfer(1'b0, 1'b1, 6'h3D, 4, 0, 1'b0);
        chk("R5 burst write 3D", int'(mem[6'h3D]), int'(pat(0, 5)));
        chk("R5 burst write 3E", int'(mem[6'h3E]), int'(pat(1, 5)));
        chk("R5 burst write 3F", int'(mem[6'h3F]), int'(pat(2, 5)));
        chk("R5 burst write wraps to 00", int'(mem[6'h00]), int'(pat(3, 5)));

        // R5: increment burst read across the wrap, 3-wire.
        xfer(1'b1, 1'b1, 6'h3E, 3, 0, 1'b1);
        chk("R5 burst read 3E", int'(rx_buf[0]), int'(pat(1, 5)));
        chk("R5 burst read 3F", int'(rx_buf[1]), int'(pat(2, 5)));
        chk("R5 burst read wrap 00", int'(rx_buf[2]), int'(pat(3, 5)));
        chk("R8 burst enable timing", oe_bad, 0);

        // R6: fixed-index burst write then read.
        begin
            int w0;
            w0 = wr_cnt;
            for (int k = 0; k < 3; k++) tx_buf[k] = pat(k, 9);
            xfer(1'b0, 1'b0, 6'h07, 3, 0, 1'b0);
            chk("R6 fixed burst strobes", wr_cnt - w0, 3);
            chk("R6 fixed burst last byte kept", int'(mem[6'h07]), int'(pat(2, 9)));
            chk("R6 neighbour untouched", int'(mem[6'h08]), int'(pat(8, 1)));
        end
        xfer(1'b1, 1'b0, 6'h07, 3, 0, 1'b0);
        for (int k = 0; k < 3; k++)
            chk("R6 fixed burst read", int'(rx_buf[k]), int'(pat(2, 9)));

        // R7: a cut block writes nothing; the full block before it does.
        begin
            int w0;
            w0 = wr_cnt;
            tx_buf[0] = 8'h5A;
            tx_buf[1] = 8'hA5;
            xfer(1'b0, 1'b1, 6'h20, 2, 3, 1'b0);
            chk("R7 only full block strobed", wr_cnt - w0, 1);
            chk("R7 full block value", int'(mem[6'h20]), 8'h5A);
            chk("R7 cut block discarded", int'(mem[6'h21]), int'(pat(6'h21, 1)));
            w0 = wr_cnt;
            tx_buf[0] = 8'hFF;
            xfer(1'b0, 1'b0, 6'h30, 1, 7, 1'b0);
            chk("R7 one-bit block no strobe", wr_cnt - w0, 0);
            chk("R7 one-bit block value kept", int'(mem[6'h30]), int'(pat(6'h30, 1)));
            w0 = wr_cnt;
            xfer(1'b0, 1'b0, 6'h31, 0, 0, 1'b0);
            chk("R7 command only no strobe", wr_cnt - w0, 0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule